// File: doc/BRIEF.md
# Return-from-interrupt state restore

This block produces the machine-state word and the next fetch address that take effect when a return-from-interrupt instruction completes. It reads three 64-bit words: the machine state now in force, the saved state captured when the interrupt was taken, and the saved return address. Most of the new state is reloaded from the saved copy. A few fields instead follow rules that depend on the current state: the machine-check enable, the transactional-state field and the hypervisor bit. When the restored state is user mode, the relocation and interrupt-enable bits are forced on.

Bits are numbered with bit 0 as the most significant bit of the 64-bit word, so bit n sits at vector index 63-n. Results are registered. They appear one clock after the select input is sampled high, each with its own valid flag. The execution pipeline raises the select for one cycle per instruction. Privilege checks and flushing are handled elsewhere.

Top module: `rfi_restore`

## Requirements
- R1: New bit 51 (machine-check enable) takes saved bit 51 when current bit 3 (hypervisor) is 1; otherwise it keeps current bit 51.
- R2: New bits 29..31 (transactional state) keep the current value only when the current field equals 0b010 and the saved field equals 0b000; in every other case they take the saved field.
- R3: New bits 48 (interrupt enable), 58 and 59 (instruction and data relocate) each equal the saved bit ORed with saved bit 49 (user mode).
- R4: New bits 0..2, 4..28, 32..47, 49..50, 52..57 and 60..63 are copies of the same bits of the saved state.
- R5: New bit 3 (hypervisor) is kept from the current state and is never loaded from the saved state.
- R6: The next address equals the saved return address with its two least significant bits forced to zero.
- R7: When select is high at a rising clock edge, both valid flags are high after that edge and the outputs carry the results for the inputs sampled at that edge.
- R8: When select is low at a rising clock edge, both valid flags are low after that edge.
- R9: A synchronous active-high reset clears both valid flags and both output words to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Return-from-interrupt operation selected this cycle |
| cur_state | input | 64 | Machine state currently in force |
| saved_addr | input | 64 | Saved return address |
| saved_state | input | 64 | Saved machine state |
| out_state | output | 64 | New machine state |
| out_state_vld | output | 1 | New machine state is valid |
| out_addr | output | 64 | Next instruction address |
| out_addr_vld | output | 1 | Next instruction address is valid |

## Verification
The block holds state only in its output registers. A wrong merge or a stale register therefore shows on the ports one clock after the select that caused it, and it lasts only until the next select. The riskiest terms are the two conditional restores and the user-mode override. The vector set drives the transactional-state guard through all four combinations of "current field is 0b010" and "saved field is 0b000", and it drives the hypervisor and user-mode bits both high and low. A valid flag left high after an idle cycle would present a stale result as new, so every vector is followed by an idle cycle.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  // Machine word width; the bit positions below assume it.
  localparam int XLEN = 64;

  // Field positions, numbered with bit 0 as the most significant bit.
  localparam int MB_HV    = 3;
  localparam int MB_TS_HI = 29;
  localparam int MB_TS_LO = 31;
  localparam int MB_EE    = 48;
  localparam int MB_PR    = 49;
  localparam int MB_ME    = 51;
  localparam int MB_IR    = 58;
  localparam int MB_DR    = 59;

  // Same positions as vector indices (LSB = 0).
  localparam int IX_HV    = XLEN - 1 - MB_HV;
  localparam int IX_TS_HI = XLEN - 1 - MB_TS_HI;
  localparam int IX_TS_LO = XLEN - 1 - MB_TS_LO;
  localparam int IX_EE    = XLEN - 1 - MB_EE;
  localparam int IX_PR    = XLEN - 1 - MB_PR;
  localparam int IX_ME    = XLEN - 1 - MB_ME;
  localparam int IX_IR    = XLEN - 1 - MB_IR;
  localparam int IX_DR    = XLEN - 1 - MB_DR;

  localparam int TS_W = IX_TS_HI - IX_TS_LO + 1;

  // Guard values for the transactional-state conditional restore.
  localparam logic [TS_W-1:0] TS_HOLD_CUR   = 3'b010;
  localparam logic [TS_W-1:0] TS_HOLD_SAVED = 3'b000;

  // Bits forced on when the restored state is user mode.
  localparam int N_FORCE = 3;
  localparam int FORCE_IX [N_FORCE] = '{IX_EE, IX_IR, IX_DR};
endpackage

// File: rtl/rfi_state_merge.sv
module rfi_state_merge
  import rfi_pkg::*;
(
  input  logic [XLEN-1:0] cur_i,
  input  logic [XLEN-1:0] saved_i,
  output logic [XLEN-1:0] merged_o
);
  logic [TS_W-1:0] cur_ts;
  logic [TS_W-1:0] saved_ts;
  logic            ts_take_saved;

  assign cur_ts        = cur_i[IX_TS_HI:IX_TS_LO];
  assign saved_ts      = saved_i[IX_TS_HI:IX_TS_LO];
  assign ts_take_saved = (cur_ts != TS_HOLD_CUR) || (saved_ts != TS_HOLD_SAVED);

  always_comb begin
    // Default: straight reload from the saved copy.
    merged_o = saved_i;
    // Hypervisor bit is never reloaded.
    merged_o[IX_HV] = cur_i[IX_HV];
    // Machine-check enable reloads only from hypervisor state.
    merged_o[IX_ME] = cur_i[IX_HV] ? saved_i[IX_ME] : cur_i[IX_ME];
    // Transactional state: conditional reload.
    merged_o[IX_TS_HI:IX_TS_LO] = ts_take_saved ? saved_ts : cur_ts;
    // User mode forces relocation and interrupt enable on.
    for (int k = 0; k < N_FORCE; k++) begin
      merged_o[FORCE_IX[k]] = saved_i[FORCE_IX[k]] | saved_i[IX_PR];
    end
  end
endmodule

// File: rtl/rfi_addr_align.sv
module rfi_addr_align #(
  parameter int WIDTH      = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic [WIDTH-1:0] addr_i,
  output logic [WIDTH-1:0] addr_o
);
  logic unused_low;
  assign unused_low = ^addr_i[ALIGN_BITS-1:0];
  assign addr_o     = {addr_i[WIDTH-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/rfi_restore.sv
module rfi_restore
  import rfi_pkg::*;
#(
  parameter int ALIGN_BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic [XLEN-1:0] cur_state,
  input  logic [XLEN-1:0] saved_addr,
  input  logic [XLEN-1:0] saved_state,
  output logic [XLEN-1:0] out_state,
  output logic            out_state_vld,
  output logic [XLEN-1:0] out_addr,
  output logic            out_addr_vld
);
  logic [XLEN-1:0] merged_state;
  logic [XLEN-1:0] aligned_addr;

  rfi_state_merge u_merge (
    .cur_i    (cur_state),
    .saved_i  (saved_state),
    .merged_o (merged_state)
  );

  rfi_addr_align #(.WIDTH(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_align (
    .addr_i (saved_addr),
    .addr_o (aligned_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_state     <= '0;
      out_addr      <= '0;
      out_state_vld <= 1'b0;
      out_addr_vld  <= 1'b0;
    end else begin
      out_state_vld <= sel;
      out_addr_vld  <= sel;
      if (sel) begin
        out_state <= merged_state;
        out_addr  <= aligned_addr;
      end
    end
  end

  // R1: machine-check enable follows saved copy in hypervisor state
  p_me_from_saved_r1: assert property (@(posedge clk) disable iff (rst)
    sel && cur_state[IX_HV] |=> out_state[IX_ME] == $past(saved_state[IX_ME]));

  // R1: otherwise it holds the current value
  p_me_kept_r1: assert property (@(posedge clk) disable iff (rst)
    sel && !cur_state[IX_HV] |=> out_state[IX_ME] == $past(cur_state[IX_ME]));

  // R2: the single hold case keeps 0b010
  p_ts_hold_r2: assert property (@(posedge clk) disable iff (rst)
    sel && cur_state[IX_TS_HI:IX_TS_LO] == TS_HOLD_CUR
        && saved_state[IX_TS_HI:IX_TS_LO] == TS_HOLD_SAVED
    |=> out_state[IX_TS_HI:IX_TS_LO] == TS_HOLD_CUR);

  // R3: user mode implies relocation and interrupt enable
  p_user_forces_r3: assert property (@(posedge clk) disable iff (rst)
    out_state_vld && out_state[IX_PR]
    |-> out_state[IX_EE] && out_state[IX_IR] && out_state[IX_DR]);

  // R5: hypervisor bit never reloaded
  p_hv_kept_r5: assert property (@(posedge clk) disable iff (rst)
    sel |=> out_state[IX_HV] == $past(cur_state[IX_HV]));

  // R6: address alignment and upper bits
  p_addr_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    sel |=> out_addr[ALIGN_BITS-1:0] == '0
        && (out_addr >> ALIGN_BITS) == ($past(saved_addr) >> ALIGN_BITS));

  // R7: both flags raised after a select
  p_vld_on_r7: assert property (@(posedge clk) disable iff (rst)
    sel |=> out_state_vld && out_addr_vld);

  // R8: both flags dropped after an idle cycle
  p_vld_off_r8: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !out_state_vld && !out_addr_vld);
endmodule

// File: tb/test_rfi_restore.sv
module test_rfi_restore;
  logic        clk = 1'b0;
  logic        rst;
  logic        sel;
  logic [63:0] cur_state, saved_addr, saved_state;
  logic [63:0] out_state, out_addr;
  logic        out_state_vld, out_addr_vld;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  rfi_restore i_rfi_restore (
    .clk(clk), .rst(rst), .sel(sel),
    .cur_state(cur_state), .saved_addr(saved_addr), .saved_state(saved_state),
    .out_state(out_state), .out_state_vld(out_state_vld),
    .out_addr(out_addr), .out_addr_vld(out_addr_vld)
  );

  localparam int NV = 8;
  localparam logic [63:0] V_CUR [NV] = '{
    64'h1000_0002_0000_1000,  // HV=1, ts=010 ; saved ts=000 -> hold
    64'h0000_0002_0000_1000,  // ts=010 ; saved ts=101 -> reload
    64'h1000_0007_0000_0000,  // ts=111 ; saved ts=000 -> reload
    64'h0000_0005_FFFF_FFFF,  // ts=101 ; saved ts=111 -> reload
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0000,
    64'h0000_0002_0000_0000,  // ts=010 ; saved ts=000 -> hold
    64'h1000_0002_0000_0000
  };
  localparam logic [63:0] V_SAV [NV] = '{
    64'h0000_0000_0000_4000,
    64'hA5A5_0005_0000_0021,
    64'hFFFF_FFF8_FFFF_BFFF,
    64'h0123_4567_89AB_CDEF,
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0000,
    64'hEFFF_FFF8_FFFF_FFFF
  };
  localparam logic [63:0] V_ADR [NV] = '{
    64'h0000_0000_0000_1003, 64'hDEAD_BEEF_0000_0101,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0002,
    64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_DEF1,
    64'h0000_0000_0000_0004, 64'h7777_7777_7777_7776
  };

  // Bit access with bit 0 as the most significant bit.
  function automatic logic gb(logic [63:0] v, int n);
    return v[63 - n];
  endfunction

  function automatic logic [63:0] model_state(logic [63:0] c, logic [63:0] s);
    logic [63:0] r = '0;
    logic [2:0]  cts = {gb(c, 29), gb(c, 30), gb(c, 31)};
    logic [2:0]  sts = {gb(s, 29), gb(s, 30), gb(s, 31)};
    for (int n = 0; n < 64; n++) begin
      if (n == 3)                   r[63 - n] = gb(c, 3);
      else if (n == 51)             r[63 - n] = gb(c, 3) ? gb(s, 51) : gb(c, 51);
      else if (n >= 29 && n <= 31)  r[63 - n] = (cts == 3'b010 && sts == 3'b000) ? gb(c, n) : gb(s, n);
      else if (n == 48 || n == 58 || n == 59) r[63 - n] = gb(s, n) | gb(s, 49);
      else                          r[63 - n] = gb(s, n);
    end
    return r;
  endfunction

  function automatic logic [63:0] msb0_mask(int lo, int hi);
    logic [63:0] m = '0;
    for (int n = lo; n <= hi; n++) m[63 - n] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_vector(int i);
    logic [63:0] e    = model_state(V_CUR[i], V_SAV[i]);
    logic [63:0] copy = msb0_mask(0, 2) | msb0_mask(4, 28) | msb0_mask(32, 47) |
                        msb0_mask(49, 50) | msb0_mask(52, 57) | msb0_mask(60, 63);
    copy[63 - 48] = 1'b0;
    check("R1 machine-check enable", 64'(out_state[63-51]), 64'(e[63-51]));
    check("R2 transactional state",  64'(out_state[34:32]), 64'(e[34:32]));
    check("R3 user-mode override",
          64'({out_state[63-48], out_state[63-58], out_state[63-59]}),
          64'({e[63-48], e[63-58], e[63-59]}));
    check("R4 copied bits", out_state & copy, V_SAV[i] & copy);
    check("R5 hypervisor kept", 64'(out_state[63-3]), 64'(V_CUR[i][63-3]));
    check("R6 next address", out_addr, {V_ADR[i][63:2], 2'b00});
    check("R7 valid flags", 64'({out_state_vld, out_addr_vld}), 64'(2'b11));
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; sel = 1'b0;
    cur_state = '1; saved_addr = '1; saved_state = '1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 state after reset", out_state, '0);
    check("R9 address after reset", out_addr, '0);
    check("R9 valids after reset", 64'({out_state_vld, out_addr_vld}), '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      sel = 1'b1;
      cur_state = V_CUR[i]; saved_state = V_SAV[i]; saved_addr = V_ADR[i];
      @(negedge clk);
      check_vector(i);
      sel = 1'b0;
      cur_state = ~V_CUR[i]; saved_state = ~V_SAV[i]; saved_addr = ~V_ADR[i];
      @(negedge clk);
      // R8: idle cycle drops valids
      check("R8 valids idle", 64'({out_state_vld, out_addr_vld}), '0);
    end

    // Back-to-back selects: second result replaces first (R7).
    sel = 1'b1;
    cur_state = V_CUR[2]; saved_state = V_SAV[2]; saved_addr = V_ADR[2];
    @(negedge clk);
    cur_state = V_CUR[3]; saved_state = V_SAV[3]; saved_addr = V_ADR[3];
    @(negedge clk);
    check_vector(3);

    // R9: reset while busy clears everything.
    rst = 1'b1;
    @(negedge clk);
    check("R9 state under reset", out_state, '0);
    check("R9 valids under reset", 64'({out_state_vld, out_addr_vld}), '0);
    rst = 1'b0; sel = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule